// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides an input clock by a programmable integer ratio and emits one single-cycle pulse per output period, at the rate a phase comparator would consume. The ratio is not produced by one wide modulo counter. Three parts build it:

- A prescaler that divides by 32 or 33, depending on a modulus-control signal.
- A 5-bit swallow counter that keeps the prescaler at 33 for the first S prescaler cycles of each period.
- An 11-bit main counter that ends the period after M prescaler cycles.

The resulting period is N = 33·S + 32·(M − S) = 32·M + S input cycles.

The swallow setting S and the main setting M come from registers and may change at any time. The block samples them only when a period starts. While reset is held, and whenever a period ends, both counters load fresh settings and the prescaler begins a divide-by-33 (or divide-by-32 when S is zero). Because S never exceeds 31 and M is forced to at least 32, the swallow counter always reaches zero before the main counter does.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_n` is low (sampled at the rising clock edge), `div_pulse` is 0 and the counters load the settings on the inputs. After `rst_n` is released, the first `div_pulse` appears exactly N rising edges later.
- R2: Between two consecutive `div_pulse` assertions there are exactly N = 32·M + S input clock cycles, where S = `swallow_cfg` (0 to 31) and M = `main_cfg` as used for that period.
- R3: `div_pulse` is high for exactly one input clock cycle per period.
- R4: A period consists of M prescaler cycles. The first S of them last 33 input cycles and the rest last 32, so each added unit of S lengthens the period by exactly one input cycle.
- R5: A `main_cfg` value below 32 is treated as 32, so the period is 1024 + S.
- R6: The settings are sampled only at the start of a period. A change during a period leaves that period's length unchanged and takes effect from the next period.
- R7: The ratio range ends are honoured: S = 0 with M = 32 gives 1024 cycles, and S = 31 with M = 2047 gives 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; restarts the period with the current settings |
| swallow_cfg | input | 5 | Swallow setting S, the number of divide-by-33 prescaler cycles per period |
| main_cfg | input | 11 | Main setting M, the number of prescaler cycles per period (values below 32 count as 32) |
| div_pulse | output | 1 | One-cycle pulse marking the end of each period of N input cycles |

## Verification
The bench checks three kinds of corner case:

- **Range ends and clamping:** S = 0 and S = 31 at the smallest M, the 65535-cycle maximum, and M values of 0 and 20, which must clamp to 32. A divider with an off-by-one in either counter, or with no clamp, gives a period shifted by one prescaler cycle or one input cycle, or a very short one.
- **Step of one in S:** S = 0 and S = 1 are compared. The period must grow by exactly one cycle, which catches a modulus control that swaps 32 and 33 or holds 33 for one cycle too many.
- **Settings changed mid-period:** settings are changed partway through a period and right after a pulse. A divider that reads its inputs continuously would shorten or stretch the running period instead of deferring the change to the next reload.

// File: rtl/div_pkg.sv
// Package: shared default dimensions of the pulse-swallow divider.
// Assumes: the prescaler base modulus is also the smallest legal main
// setting, so the swallow count never exceeds the main count.
package div_pkg;
    localparam int DEF_PRE_BASE = 32;  // low modulus of the prescaler
    localparam int DEF_SW_W     = 5;   // swallow setting width
    localparam int DEF_MN_W     = 11;  // main setting width
endpackage

// File: rtl/dual_mod_prescaler.sv
// Module: dual-modulus prescaler, divides by BASE or BASE+1.
// Assumes: mod_hi_next is valid whenever the counter reloads (reset,
// period restart or terminal count) and picks the length of the next
// prescaler cycle. tc is high in the last input cycle of each prescaler cycle.
module dual_mod_prescaler #(
    parameter int BASE = div_pkg::DEF_PRE_BASE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic mod_hi_next,
    output logic tc
);
    localparam int CW = $clog2(BASE + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload_val;

    // Purpose: reload value gives a cycle of BASE+1 or BASE input clocks.
    always_comb begin
        reload_val = mod_hi_next ? CW'(BASE) : CW'(BASE - 1);
    end

    // Purpose: count down and reload on reset, restart or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tc) begin
            cnt <= reload_val;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tc = (cnt == '0);
endmodule

// File: rtl/swallow_ctr.sv
// Module: swallow counter; drives the prescaler modulus control.
// Assumes: decremented once per prescaler terminal count, and loaded with
// the swallow setting at each period restart. While it is non-zero the
// prescaler runs at its high modulus.
module swallow_ctr #(
    parameter int W = div_pkg::DEF_SW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tc,
    input  logic [W-1:0] s_cfg,
    output logic         mod_hi_next
);
    logic [W-1:0] sw_cnt;

    // Purpose: load on restart, count swallowed cycles down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sw_cnt <= s_cfg;
        end else if (tc && (sw_cnt != '0)) begin
            sw_cnt <= sw_cnt - 1'b1;
        end
    end

    // Purpose: modulus of the prescaler cycle that begins after this edge.
    always_comb begin
        if (!rst_n || restart) begin
            mod_hi_next = (s_cfg != '0);
        end else if (tc) begin
            mod_hi_next = (sw_cnt > W'(1));
        end else begin
            mod_hi_next = (sw_cnt != '0);
        end
    end
endmodule

// File: rtl/main_ctr.sv
// Module: main counter; ends the period after M prescaler cycles.
// Assumes: m_cfg below MIN is raised to MIN. period_end is high in the
// final input cycle of the period and doubles as the restart request.
module main_ctr #(
    parameter int W   = div_pkg::DEF_MN_W,
    parameter int MIN = div_pkg::DEF_PRE_BASE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tc,
    input  logic [W-1:0] m_cfg,
    output logic         period_end
);
    logic [W-1:0] mn_cnt;
    logic [W-1:0] m_eff;

    // Purpose: clamp the main setting to its legal minimum.
    always_comb begin
        m_eff = (m_cfg < W'(MIN)) ? W'(MIN) : m_cfg;
    end

    // Purpose: load at restart, count prescaler cycles down.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end) begin
            mn_cnt <= m_eff;
        end else if (tc) begin
            mn_cnt <= mn_cnt - 1'b1;
        end
    end

    assign period_end = tc && (mn_cnt == W'(1));
endmodule

// File: rtl/pulse_swallow_divider.sv
// Module: top of the pulse-swallow divider; period = BASE*M + S cycles.
// Assumes: swallow_cfg and main_cfg come from registers and may change at
// any time; they are used only at a period restart. Reset is synchronous
// and active low.
module pulse_swallow_divider #(
    parameter int PRE_BASE = div_pkg::DEF_PRE_BASE,
    parameter int SW_W     = div_pkg::DEF_SW_W,
    parameter int MN_W     = div_pkg::DEF_MN_W
) (
    input  logic            clk_in,
    input  logic            rst_n,
    input  logic [SW_W-1:0] swallow_cfg,
    input  logic [MN_W-1:0] main_cfg,
    output logic            div_pulse
);
    logic presc_tc;
    logic mod_hi_next;
    logic period_end;

    dual_mod_prescaler #(.BASE(PRE_BASE)) u_presc (
        .clk         (clk_in),
        .rst_n       (rst_n),
        .restart     (period_end),
        .mod_hi_next (mod_hi_next),
        .tc          (presc_tc)
    );

    swallow_ctr #(.W(SW_W)) u_swallow (
        .clk         (clk_in),
        .rst_n       (rst_n),
        .restart     (period_end),
        .tc          (presc_tc),
        .s_cfg       (swallow_cfg),
        .mod_hi_next (mod_hi_next)
    );

    main_ctr #(.W(MN_W), .MIN(PRE_BASE)) u_main (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .tc         (presc_tc),
        .m_cfg      (main_cfg),
        .period_end (period_end)
    );

    // Purpose: register the end-of-period strobe as the output pulse.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= period_end;
        end
    end
endmodule

// File: rtl/pulse_swallow_divider_chk.sv
// Module: assertion checker bound to pulse_swallow_divider.
// Assumes: it sees the prescaler terminal count and the period-end strobe
// of the top and keeps its own cycle counters to judge their spacing.
module pulse_swallow_divider_chk #(
    parameter int PRE_BASE = div_pkg::DEF_PRE_BASE,
    parameter int SW_W     = div_pkg::DEF_SW_W,
    parameter int MN_W     = div_pkg::DEF_MN_W
) (
    input logic            clk_in,
    input logic            rst_n,
    input logic [SW_W-1:0] swallow_cfg,
    input logic [MN_W-1:0] main_cfg,
    input logic            div_pulse,
    input logic            presc_tc,
    input logic            period_end
);
    localparam int PW = SW_W + MN_W + 1;
    localparam int GW = $clog2(PRE_BASE + 2);

    logic [PW-1:0] per_cnt;
    logic [PW-1:0] per_exp;
    logic [GW-1:0] gap_cnt;
    logic [MN_W-1:0] m_eff;

    // Purpose: independent clamp of the main setting.
    always_comb begin
        m_eff = (main_cfg < MN_W'(PRE_BASE)) ? MN_W'(PRE_BASE) : main_cfg;
    end

    // Purpose: expected period and elapsed cycles in the current period.
    always_ff @(posedge clk_in) begin
        if (!rst_n || period_end) begin
            per_exp <= PW'(PRE_BASE) * PW'(m_eff) + PW'(swallow_cfg);
            per_cnt <= PW'(1);
        end else begin
            per_cnt <= per_cnt + 1'b1;
        end
    end

    // Purpose: input cycles since the last prescaler terminal count.
    always_ff @(posedge clk_in) begin
        if (!rst_n || presc_tc) begin
            gap_cnt <= GW'(1);
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R1: no pulse in the first cycle after reset release.
    a_r1_quiet_after_reset: assert property (@(posedge clk_in) disable iff (!rst_n)
        $past(!rst_n) |-> !div_pulse);

    // R2 and R5: the period ends exactly at the expected cycle count.
    a_r2_period_len: assert property (@(posedge clk_in) disable iff (!rst_n)
        period_end |-> (per_cnt == per_exp));

    // R3: the output pulse lasts a single cycle.
    a_r3_pulse_one_cycle: assert property (@(posedge clk_in) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R4: every prescaler cycle is BASE or BASE+1 input cycles long.
    a_r4_presc_gap: assert property (@(posedge clk_in) disable iff (!rst_n)
        presc_tc |-> ((gap_cnt == GW'(PRE_BASE)) || (gap_cnt == GW'(PRE_BASE + 1))));
endmodule

bind pulse_swallow_divider pulse_swallow_divider_chk #(
    .PRE_BASE (PRE_BASE),
    .SW_W     (SW_W),
    .MN_W     (MN_W)
) u_chk (
    .clk_in      (clk_in),
    .rst_n       (rst_n),
    .swallow_cfg (swallow_cfg),
    .main_cfg    (main_cfg),
    .div_pulse   (div_pulse),
    .presc_tc    (presc_tc),
    .period_end  (period_end)
);

// File: tb/pulse_swallow_divider_tb.sv
// Bench: directed corners plus seeded random settings for the divider.
module pulse_swallow_divider_tb;
    logic        clk_in = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  swallow_cfg = '0;
    logic [10:0] main_cfg = 11'd32;
    logic        div_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    pulse_swallow_divider u_dut (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .swallow_cfg (swallow_cfg),
        .main_cfg    (main_cfg),
        .div_pulse   (div_pulse)
    );

    always #5 clk_in = ~clk_in;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk_in) begin
        cyc++;
        if (cyc > 199000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 199000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int exp_period(int s, int m);
        return 32 * ((m < 32) ? 32 : m) + s;
    endfunction

    task automatic check(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Count rising edges from the current negedge until div_pulse is seen.
    // When width_chk is set the start point is a pulse, so one cycle later
    // the output must be low again (R3). At change_at new settings are driven.
    task automatic measure(output int cycles, input bit width_chk,
                           input int change_at, input int s2, input int m2);
        cycles = 0;
        while (1) begin
            @(posedge clk_in);
            cycles++;
            @(negedge clk_in);
            if (width_chk && cycles == 1) check("R3 pulse width", int'(div_pulse), 0);
            if (cycles == change_at) begin
                swallow_cfg = 5'(s2);
                main_cfg    = 11'(m2);
            end
            if (div_pulse) break;
            if (cycles > 70000) break;
        end
    endtask

    task automatic restart(int s, int m);
        @(negedge clk_in);
        rst_n = 1'b0;
        swallow_cfg = 5'(s);
        main_cfg    = 11'(m);
        repeat (3) @(negedge clk_in);
        check("R1 low in reset", int'(div_pulse), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int got;
        int unsigned seed_init;
        int s_prev;
        int m_prev;
        seed_init = $urandom(32'd2718);

        // R1, R7: smallest ratio, first pulse counted from release.
        restart(0, 32);
        measure(got, 1'b0, -1, 0, 0);
        check("R1 first pulse after reset", got, 1024);
        measure(got, 1'b1, -1, 0, 0);
        check("R7 min ratio S=0 M=32", got, exp_period(0, 32));

        // R4: one swallowed cycle adds exactly one input cycle.
        restart(1, 32);
        measure(got, 1'b0, -1, 0, 0);
        check("R4 S=1 adds one cycle", got, 1025);

        restart(31, 32);
        measure(got, 1'b0, -1, 0, 0);
        check("R2 S=31 M=32", got, 1055);
        measure(got, 1'b1, -1, 0, 0);
        check("R2 S=31 M=32 repeat", got, 1055);

        // R5: main values below 32 are clamped.
        restart(7, 20);
        measure(got, 1'b0, -1, 0, 0);
        check("R5 M=20 clamped", got, 1031);
        restart(0, 0);
        measure(got, 1'b0, -1, 0, 0);
        check("R5 M=0 clamped", got, 1024);

        // R6: a change in mid-period waits for the next reload.
        restart(3, 40);
        measure(got, 1'b0, 600, 20, 50);
        check("R6 current period kept", got, exp_period(3, 40));
        measure(got, 1'b1, -1, 0, 0);
        check("R6 new setting next period", got, exp_period(20, 50));

        // R2, R6: seeded random settings, changed right after a pulse.
        s_prev = 20;
        m_prev = 50;
        for (int i = 0; i < 6; i++) begin
            int s_new;
            int m_new;
            s_new = int'($urandom % 32);
            m_new = 32 + int'($urandom % 90);
            swallow_cfg = 5'(s_new);
            main_cfg    = 11'(m_new);
            measure(got, 1'b1, -1, 0, 0);
            check("R6 random old period", got, exp_period(s_prev, m_prev));
            measure(got, 1'b1, -1, 0, 0);
            check("R2 random period", got, exp_period(s_new, m_new));
            s_prev = s_new;
            m_prev = m_new;
        end

        // R7: largest ratio.
        restart(31, 2047);
        measure(got, 1'b0, -1, 0, 0);
        check("R7 max ratio S=31 M=2047", got, 65535);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule